// File: doc/BRIEF.md
# Command-Aware Lane Striper for a Dual-Lane SPI Flash Path

This block sits between a transmit byte queue and a set of SPI byte lanes. Each time it is kicked, it drains the transmit queue one lane transfer at a time. While it drains, it follows the framing of a serial-flash command. The first byte of each chip-select frame is taken as the opcode. The opcode tells the block how many address, mode and dummy bytes come next, and the block counts down through them. All of those bytes are broadcast, meaning the same byte goes out on every lane.

Once the count runs out, the frame enters its data phase. When wide mode is on and enough bytes are queued, each transfer takes one byte per lane from the queue and spreads their bits across the lanes. Bit i of the combined stream goes to lane (i mod LANES), at bit position (i div LANES). The bytes returned by the lanes are de-interleaved with the exact inverse mapping and pushed back as a group.

When the drain finds the queue empty, it raises a one-cycle underflow event and stops. A receive queue that is full when a transfer completes causes the returned data to be dropped, and a one-cycle overflow event is raised instead.

Top module: `snoop_striper`

## Requirements
- R1: While and right after reset, `tx_pop`, `xfer_req`, `rx_push` and both event outputs are low, and the command tracker is in its checking state.
- R2: In the checking state, the first byte sent sets the count of further broadcast bytes. Opcodes 0x03, 0x02, 0xA2 and 0x32 give 3. Opcodes 0x0B, 0x3B, 0x6B and 0xBB give 4. Opcode 0xEB gives 6. Each later transfer lowers the count by one, and striping is allowed once the count reaches zero.
- R3: Any other opcode puts the tracker in a no-striping state, and every remaining byte of that frame is broadcast.
- R4: Whenever `frame_active` is low, the tracker returns to checking. While the frame stays active, the tracker keeps its state from one kick to the next.
- R5: A broadcast transfer pops one byte and drives it on every lane of `lane_tx`. Only lane 0's returned byte is pushed, in `rx_data[7:0]`, with `rx_push_multi` low.
- R6: A striped transfer pops LANES bytes (`tx_pop_multi` high). Byte 0 is `tx_head[7:0]`, and the stream is formed with byte 0's bit 0 as stream bit 0. Stream bit i drives `lane_tx` bit (i mod LANES)*8 + (i div LANES).
- R7: After a striped transfer, the returned lane bits go through the inverse mapping. The resulting LANES bytes are pushed at once with `rx_push_multi` high, byte 0 in `rx_data[7:0]`.
- R8: If `rx_full` is high when a transfer completes, nothing is pushed and `ev_rx_overflow` pulses for one cycle.
- R9: A transfer attempt with `tx_level` zero pulses `ev_tx_underflow` for one cycle, starts no transfer and ends the drain.
- R10: With `wide_en` low, or with fewer than LANES bytes queued, a transfer in the data phase broadcasts one byte.
- R11: `xfer_req` stays high with `lane_tx` unchanged until `xfer_done` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wide_en | input | 1 | All LANES lanes in use; allows striping |
| frame_active | input | 1 | A chip select is asserted; low returns tracker to checking |
| flush_kick | input | 1 | One-cycle pulse that starts draining the transmit queue |
| tx_level | input | LVL_W (9) | Bytes currently held in the transmit queue |
| tx_head | input | LANES*8 (16) | Oldest LANES queued bytes, byte 0 in the low bits |
| tx_pop | output | 1 | Remove bytes from the transmit queue this cycle |
| tx_pop_multi | output | 1 | With `tx_pop`: remove LANES bytes instead of one |
| lane_tx | output | LANES*8 (16) | Byte for each lane, lane j in bits j*8 +: 8 |
| xfer_req | output | 1 | Lane transfer requested; held until `xfer_done` |
| xfer_done | input | 1 | Lane transfer finished; `lane_rx` valid |
| lane_rx | input | LANES*8 (16) | Byte returned by each lane |
| rx_full | input | 1 | Receive queue cannot accept data |
| rx_push | output | 1 | Write to the receive queue this cycle |
| rx_push_multi | output | 1 | With `rx_push`: LANES bytes are written instead of one |
| rx_data | output | LANES*8 (16) | Bytes to write, byte 0 in the low bits |
| ev_tx_underflow | output | 1 | One-cycle pulse: drain found the queue empty |
| ev_rx_overflow | output | 1 | One-cycle pulse: returned data dropped on a full queue |

## Verification
The assertions check, on every cycle, the rules that depend only on nearby cycles. They cover the following: pops never happen on an empty queue; a multi-byte pop happens only in the data phase with wide mode on; pushes never coincide with a full queue; a low frame select forces the tracker back to checking; and a pending request keeps its lane bytes. The bench's scenarios are the only place where the sequence-level behaviour can be shown. That includes the number of broadcast transfers each opcode class produces, the exact bit placement of the interleave and its inverse on returned data, tracker persistence across separate kicks, and the fallback to broadcast for an odd trailing byte or a single lane.

// File: rtl/snp_pkg.sv
// Shared constants, types and the opcode classifier for the lane striper.
// Assumes byte-wide lanes; the tracker value is one byte wide.
package snp_pkg;

    localparam logic [7:0] SNP_CHECK = 8'hFF;
    localparam logic [7:0] SNP_NONE  = 8'hFE;
    localparam logic [7:0] SNP_DATA  = 8'h00;

    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,
        SEQ_ISSUE = 2'd1,
        SEQ_WAIT  = 2'd2
    } seq_state_t;

    // Map a frame's opcode byte to the tracker's next value.
    function automatic logic [7:0] snp_classify(input logic [7:0] op);
        logic [7:0] nxt;
        case (op)
            8'h03, 8'h02, 8'hA2, 8'h32: nxt = 8'd3;
            8'h0B, 8'h3B, 8'h6B, 8'hBB: nxt = 8'd4;
            8'hEB:                      nxt = 8'd6;
            default:                    nxt = SNP_NONE;
        endcase
        return nxt;
    endfunction

endpackage

// File: rtl/snp_lane_map.sv
// Bit interleaver and its inverse across LANES byte lanes.
// Stream bit i (byte 0 bit 0 first) maps to lane (i % LANES), bit (i / LANES).
// Purely combinational; assumes lane j occupies bits j*8 +: 8.
module snp_lane_map #(
    parameter int LANES = 2
) (
    input  logic [LANES*8-1:0] bytes_in,
    output logic [LANES*8-1:0] lanes_out,
    input  logic [LANES*8-1:0] lanes_in,
    output logic [LANES*8-1:0] bytes_out
);
    localparam int NBITS = LANES * 8;

    // One wire pair per stream bit: forward and inverse routing.
    for (genvar i = 0; i < NBITS; i++) begin : g_bit
        localparam int POS = (i % LANES) * 8 + (i / LANES);
        assign lanes_out[POS] = bytes_in[i];
        assign bytes_out[i]   = lanes_in[POS];
    end

endmodule

// File: rtl/snp_snoop_tracker.sv
// Command tracker: classifies the first byte of a frame, counts down the
// address/dummy bytes, then holds in the data or no-striping state.
// Assumes adv pulses once per completed lane transfer with op = byte sent.
module snp_snoop_tracker
    import snp_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       frame_active,
    input  logic       adv,
    input  logic [7:0] op,
    output logic [7:0] state,
    output logic       striping
);
    logic [7:0] state_q;

    // Advance the tracker on each completed transfer; frame end forces checking.
    always_ff @(posedge clk) begin
        if (!rst_n || !frame_active) begin
            state_q <= SNP_CHECK;
        end else if (adv) begin
            case (state_q)
                SNP_CHECK: state_q <= snp_classify(op);
                SNP_NONE:  state_q <= SNP_NONE;
                SNP_DATA:  state_q <= SNP_DATA;
                default:   state_q <= state_q - 8'd1;
            endcase
        end
    end

    assign state    = state_q;
    assign striping = (state_q == SNP_DATA);

endmodule

// File: rtl/snp_sequencer.sv
// Transfer sequencer: drains the transmit queue one lane transfer at a time,
// chooses broadcast or striped issue, waits for completion and routes the
// returned bytes to the receive queue. Assumes tx_level/tx inputs are stable
// within a cycle and xfer_done is only meaningful while xfer_req is high.
module snp_sequencer
    import snp_pkg::*;
#(
    parameter int LANES = 2,
    parameter int LVL_W = 9
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               kick,
    input  logic               wide_en,
    input  logic               striping,
    input  logic [LVL_W-1:0]   tx_level,
    input  logic [7:0]         tx_byte0,
    input  logic [LANES*8-1:0] striped_lanes,
    output logic               tx_pop,
    output logic               tx_pop_multi,
    output logic [LANES*8-1:0] lane_tx,
    output logic               xfer_req,
    input  logic               xfer_done,
    input  logic [7:0]         rx_lane0,
    input  logic [LANES*8-1:0] rx_unstriped,
    input  logic               rx_full,
    output logic               rx_push,
    output logic               rx_push_multi,
    output logic [LANES*8-1:0] rx_data,
    output logic               ev_tx_underflow,
    output logic               ev_rx_overflow,
    output logic               adv,
    output logic [7:0]         sent_op
);
    localparam logic [LVL_W-1:0] LVL_LANES = LVL_W'(LANES);

    seq_state_t         st_q, st_d;
    logic [LANES*8-1:0] lanes_q;
    logic               multi_q;
    logic [7:0]         op_q;
    logic               use_stripe;
    logic               issue;

    // Decide whether the next issue can interleave across all lanes.
    always_comb begin
        use_stripe = striping && wide_en && (tx_level >= LVL_LANES);
        issue      = (st_q == SEQ_ISSUE) && (tx_level != '0);
    end

    // Next-state and per-cycle strobes of the drain sequence.
    always_comb begin
        st_d            = st_q;
        ev_tx_underflow = 1'b0;
        ev_rx_overflow  = 1'b0;
        rx_push         = 1'b0;
        adv             = 1'b0;
        case (st_q)
            SEQ_IDLE: begin
                if (kick) st_d = SEQ_ISSUE;
            end
            SEQ_ISSUE: begin
                if (tx_level == '0) begin
                    ev_tx_underflow = 1'b1;
                    st_d            = SEQ_IDLE;
                end else begin
                    st_d = SEQ_WAIT;
                end
            end
            SEQ_WAIT: begin
                if (xfer_done) begin
                    adv            = 1'b1;
                    rx_push        = !rx_full;
                    ev_rx_overflow = rx_full;
                    st_d           = SEQ_ISSUE;
                end
            end
            default: st_d = SEQ_IDLE;
        endcase
    end

    // State register and capture of the lane bytes at issue time.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= SEQ_IDLE;
            lanes_q <= '0;
            multi_q <= 1'b0;
            op_q    <= '0;
        end else begin
            st_q <= st_d;
            if (issue) begin
                lanes_q <= use_stripe ? striped_lanes : {LANES{tx_byte0}};
                multi_q <= use_stripe;
                op_q    <= tx_byte0;
            end
        end
    end

    // Output drive derived from state and captured issue data.
    always_comb begin
        tx_pop        = issue;
        tx_pop_multi  = issue && use_stripe;
        xfer_req      = (st_q == SEQ_WAIT);
        lane_tx       = lanes_q;
        rx_push_multi = rx_push && multi_q;
        rx_data       = multi_q ? rx_unstriped
                                : {{(LANES-1)*8{1'b0}}, rx_lane0};
        sent_op       = op_q;
    end

endmodule

// File: rtl/snoop_striper.sv
// Top: command-aware lane striper. Wires the command tracker, the bit
// interleaver/de-interleaver and the transfer sequencer together.
// Assumes an external queue that presents its oldest LANES bytes on tx_head.
module snoop_striper #(
    parameter int LANES      = 2,
    parameter int FIFO_DEPTH = 256,
    parameter int LVL_W      = $clog2(FIFO_DEPTH + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wide_en,
    input  logic               frame_active,
    input  logic               flush_kick,
    input  logic [LVL_W-1:0]   tx_level,
    input  logic [LANES*8-1:0] tx_head,
    output logic               tx_pop,
    output logic               tx_pop_multi,
    output logic [LANES*8-1:0] lane_tx,
    output logic               xfer_req,
    input  logic               xfer_done,
    input  logic [LANES*8-1:0] lane_rx,
    input  logic               rx_full,
    output logic               rx_push,
    output logic               rx_push_multi,
    output logic [LANES*8-1:0] rx_data,
    output logic               ev_tx_underflow,
    output logic               ev_rx_overflow
);
    logic [7:0]         snoop_q;
    logic               striping;
    logic               adv;
    logic [7:0]         sent_op;
    logic [LANES*8-1:0] striped_lanes;
    logic [LANES*8-1:0] rx_unstriped;

    snp_snoop_tracker u_tracker (
        .clk          (clk),
        .rst_n        (rst_n),
        .frame_active (frame_active),
        .adv          (adv),
        .op           (sent_op),
        .state        (snoop_q),
        .striping     (striping)
    );

    snp_lane_map #(.LANES(LANES)) u_map (
        .bytes_in  (tx_head),
        .lanes_out (striped_lanes),
        .lanes_in  (lane_rx),
        .bytes_out (rx_unstriped)
    );

    snp_sequencer #(.LANES(LANES), .LVL_W(LVL_W)) u_seq (
        .clk             (clk),
        .rst_n           (rst_n),
        .kick            (flush_kick),
        .wide_en         (wide_en),
        .striping        (striping),
        .tx_level        (tx_level),
        .tx_byte0        (tx_head[7:0]),
        .striped_lanes   (striped_lanes),
        .tx_pop          (tx_pop),
        .tx_pop_multi    (tx_pop_multi),
        .lane_tx         (lane_tx),
        .xfer_req        (xfer_req),
        .xfer_done       (xfer_done),
        .rx_lane0        (lane_rx[7:0]),
        .rx_unstriped    (rx_unstriped),
        .rx_full         (rx_full),
        .rx_push         (rx_push),
        .rx_push_multi   (rx_push_multi),
        .rx_data         (rx_data),
        .ev_tx_underflow (ev_tx_underflow),
        .ev_rx_overflow  (ev_rx_overflow),
        .adv             (adv),
        .sent_op         (sent_op)
    );

endmodule

// File: rtl/snoop_striper_chk.sv
// Checker for snoop_striper: cycle-level protocol rules, bound to the top.
module snoop_striper_chk #(
    parameter int LANES = 2,
    parameter int LVL_W = 9
) (
    input logic               clk,
    input logic               rst_n,
    input logic               wide_en,
    input logic               frame_active,
    input logic [LVL_W-1:0]   tx_level,
    input logic               tx_pop,
    input logic               tx_pop_multi,
    input logic [LANES*8-1:0] lane_tx,
    input logic               xfer_req,
    input logic               xfer_done,
    input logic               rx_full,
    input logic               rx_push,
    input logic               ev_tx_underflow,
    input logic               ev_rx_overflow,
    input logic [7:0]         snoop_state
);
    localparam logic [LVL_W-1:0] LVL_LANES = LVL_W'(LANES);

    AST_RESET_QUIET: assert property (@(posedge clk) !rst_n |=> (!tx_pop && !xfer_req && !rx_push && snoop_state == 8'hFF)); // R1
    AST_FRAME_END_CHECK: assert property (@(posedge clk) disable iff (!rst_n) !frame_active |=> snoop_state == 8'hFF); // R4
    AST_MULTI_IN_DATA: assert property (@(posedge clk) disable iff (!rst_n) tx_pop_multi |-> (snoop_state == 8'h00 && wide_en && tx_level >= LVL_LANES)); // R6
    AST_NONE_NO_MULTI: assert property (@(posedge clk) disable iff (!rst_n) (snoop_state == 8'hFE) |-> !tx_pop_multi); // R3
    AST_NO_PUSH_FULL: assert property (@(posedge clk) disable iff (!rst_n) rx_push |-> !rx_full); // R8
    AST_NO_OVERFLOW_PUSH: assert property (@(posedge clk) disable iff (!rst_n) ev_rx_overflow |-> !rx_push); // R8
    AST_UNDERFLOW_EMPTY: assert property (@(posedge clk) disable iff (!rst_n) ev_tx_underflow |-> (tx_level == '0 && !tx_pop && !xfer_req)); // R9
    AST_POP_NOT_EMPTY: assert property (@(posedge clk) disable iff (!rst_n) tx_pop |-> tx_level != '0); // R9
    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n) (xfer_req && !xfer_done) |=> (xfer_req && $stable(lane_tx))); // R11

endmodule

bind snoop_striper snoop_striper_chk #(.LANES(LANES), .LVL_W(LVL_W)) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .wide_en         (wide_en),
    .frame_active    (frame_active),
    .tx_level        (tx_level),
    .tx_pop          (tx_pop),
    .tx_pop_multi    (tx_pop_multi),
    .lane_tx         (lane_tx),
    .xfer_req        (xfer_req),
    .xfer_done       (xfer_done),
    .rx_full         (rx_full),
    .rx_push         (rx_push),
    .ev_tx_underflow (ev_tx_underflow),
    .ev_rx_overflow  (ev_rx_overflow),
    .snoop_state     (snoop_q)
);

// File: tb/snoop_striper_test.sv
// Directed bench: a queue model feeds tx_head, a lane model answers each
// transfer with lane_tx ^ 8'h5A per lane after three waiting cycles.
module snoop_striper_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wide_en = 1'b1;
    logic        frame_active = 1'b0;
    logic        flush_kick = 1'b0;
    logic [8:0]  tx_level;
    logic [15:0] tx_head;
    logic        tx_pop, tx_pop_multi;
    logic [15:0] lane_tx;
    logic        xfer_req;
    logic        xfer_done = 1'b0;
    logic [15:0] lane_rx = '0;
    logic        rx_full = 1'b0;
    logic        rx_push, rx_push_multi;
    logic [15:0] rx_data;
    logic        ev_tx_underflow, ev_rx_overflow;

    always #10 clk = ~clk;

    snoop_striper uut (
        .clk(clk), .rst_n(rst_n), .wide_en(wide_en), .frame_active(frame_active),
        .flush_kick(flush_kick), .tx_level(tx_level), .tx_head(tx_head),
        .tx_pop(tx_pop), .tx_pop_multi(tx_pop_multi), .lane_tx(lane_tx),
        .xfer_req(xfer_req), .xfer_done(xfer_done), .lane_rx(lane_rx),
        .rx_full(rx_full), .rx_push(rx_push), .rx_push_multi(rx_push_multi),
        .rx_data(rx_data), .ev_tx_underflow(ev_tx_underflow),
        .ev_rx_overflow(ev_rx_overflow)
    );

    // Transmit queue model
    logic [7:0] fq [0:511];
    logic [8:0] frd = '0;
    logic [8:0] fwr = '0;
    assign tx_level = fwr - frd;
    assign tx_head  = {fq[frd + 9'd1], fq[frd]};

    // Logs
    logic [15:0] xl [0:63];
    logic [7:0]  rxb [0:127];
    int nx, nrx, ucnt, ocnt, stab_err;
    int checks = 0;
    int fails = 0;
    logic [7:0] stage [0:15];

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic finish_up();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    // Queue and lane models: sample at the falling edge, apply after the rising edge.
    initial begin
        logic p, p2, dn;
        logic [15:0] held;
        int wcnt;
        wcnt = 0;
        held = '0;
        for (int i = 0; i < 512; i++) fq[i] = '0;
        @(posedge rst_n);
        forever begin
            @(negedge clk);
            p  = tx_pop;
            p2 = tx_pop_multi;
            dn = 1'b0;
            if (rx_push) begin
                rxb[nrx] = rx_data[7:0];
                nrx++;
                if (rx_push_multi) begin
                    rxb[nrx] = rx_data[15:8];
                    nrx++;
                end
            end
            if (ev_tx_underflow) ucnt++;
            if (ev_rx_overflow) ocnt++;
            if (xfer_req && !xfer_done) begin
                if (wcnt == 0) held = lane_tx;
                else if (lane_tx !== held) stab_err++;
                wcnt++;
                if (wcnt == 3) begin
                    dn = 1'b1;
                    wcnt = 0;
                    xl[nx] = lane_tx;
                    nx++;
                end
            end
            @(posedge clk);
            #1;
            if (p) frd = frd + (p2 ? 9'd2 : 9'd1);
            xfer_done = dn;
            lane_rx = lane_tx ^ 16'h5A5A;
        end
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual hung expected finished");
        finish_up();
    end

    task automatic clear_logs();
        nx = 0; nrx = 0; ucnt = 0; ocnt = 0; stab_err = 0;
    endtask

    task automatic new_frame();
        @(posedge clk); #1 frame_active = 1'b0;
        repeat (2) @(posedge clk);
        #1 frame_active = 1'b1;
    endtask

    task automatic kick_and_wait();
        int t;
        @(posedge clk); #1 flush_kick = 1'b1;
        @(posedge clk); #1 flush_kick = 1'b0;
        t = 0;
        while (ucnt == 0 && t < 4000) begin
            @(posedge clk);
            t++;
        end
        repeat (2) @(posedge clk);
    endtask

    // Load n staged bytes, drain them and compare against the spec model:
    // the first nb transfers broadcast, then pairs stripe when wide_en.
    task automatic run_frame(input string tag, input int n, input int nb);
        int idx, k, r;
        logic [15:0] s, el, rl, rs;
        clear_logs();
        for (int i = 0; i < n; i++) begin
            fq[fwr] = stage[i];
            fwr = fwr + 9'd1;
        end
        kick_and_wait();
        idx = 0; k = 0; r = 0;
        while (idx < n) begin
            if (idx < nb || !wide_en || (n - idx) < 2) begin
                el = {stage[idx], stage[idx]};
                check({tag, " broadcast lanes"}, xl[k], el);
                check({tag, " lane0 return"}, rxb[r], stage[idx] ^ 8'h5A);
                idx++; r++;
            end else begin
                s = {stage[idx+1], stage[idx]};
                el = '0;
                for (int i = 0; i < 16; i++) el[(i % 2) * 8 + i / 2] = s[i];
                check({tag, " R6 striped lanes"}, xl[k], el);
                rl = el ^ 16'h5A5A;
                for (int i = 0; i < 16; i++) rs[i] = rl[(i % 2) * 8 + i / 2];
                check({tag, " R7 unstriped byte0"}, rxb[r], rs[7:0]);
                check({tag, " R7 unstriped byte1"}, rxb[r+1], rs[15:8]);
                idx += 2; r += 2;
            end
            k++;
        end
        check({tag, " transfer count"}, nx, k);
        check({tag, " R9 single underflow"}, ucnt, 1);
        check({tag, " R11 lanes held"}, stab_err, 0);
    endtask

    task automatic t_reset();
        check("R1 tx_pop", tx_pop, 0);
        check("R1 xfer_req", xfer_req, 0);
        check("R1 rx_push", rx_push, 0);
        check("R1 events", {ev_tx_underflow, ev_rx_overflow}, 0);
    endtask

    task automatic t_read_cmd();
        stage[0] = 8'h03; stage[1] = 8'h12; stage[2] = 8'h34; stage[3] = 8'h56;
        stage[4] = 8'hC3; stage[5] = 8'h81; stage[6] = 8'h0F; stage[7] = 8'hA5;
        new_frame();
        run_frame("R2 R5 opcode 03", 8, 4);
    endtask

    task automatic t_fast_read();
        stage[0] = 8'h3B;
        for (int i = 1; i < 10; i++) stage[i] = 8'(i * 37 + 5);
        new_frame();
        run_frame("R2 opcode 3B", 9, 5);
    endtask

    task automatic t_quad_io();
        stage[0] = 8'hEB;
        for (int i = 1; i < 11; i++) stage[i] = 8'(i * 71 + 3);
        new_frame();
        run_frame("R2 opcode EB", 11, 7);
    endtask

    task automatic t_unknown();
        stage[0] = 8'h9F;
        for (int i = 1; i < 7; i++) stage[i] = 8'(i * 19 + 200);
        new_frame();
        run_frame("R3 opcode 9F", 7, 7);
    endtask

    task automatic t_persist();
        stage[0] = 8'h02; stage[1] = 8'h01; stage[2] = 8'h02; stage[3] = 8'h03;
        new_frame();
        run_frame("R4 first kick", 4, 4);
        stage[0] = 8'hF0; stage[1] = 8'h3C;
        run_frame("R4 kept data state", 2, 0);
        stage[0] = 8'h11; stage[1] = 8'h22;
        new_frame();
        run_frame("R4 back to checking", 2, 2);
    endtask

    task automatic t_single_lane();
        wide_en = 1'b0;
        stage[0] = 8'hA2; stage[1] = 8'h00; stage[2] = 8'h10; stage[3] = 8'h20;
        stage[4] = 8'h96; stage[5] = 8'h69;
        new_frame();
        run_frame("R10 one lane", 6, 6);
        wide_en = 1'b1;
    endtask

    task automatic t_odd_tail();
        stage[0] = 8'h32; stage[1] = 8'h44; stage[2] = 8'h55; stage[3] = 8'h66;
        stage[4] = 8'h5E; stage[5] = 8'hE7; stage[6] = 8'h3D;
        new_frame();
        run_frame("R10 odd tail", 7, 4);
    endtask

    task automatic t_overflow();
        new_frame();
        clear_logs();
        rx_full = 1'b1;
        fq[fwr] = 8'h77;
        fwr = fwr + 9'd1;
        kick_and_wait();
        rx_full = 1'b0;
        check("R8 overflow pulses", ocnt, 1);
        check("R8 nothing pushed", nrx, 0);
        check("R8 transfer done", nx, 1);
    endtask

    task automatic t_empty();
        clear_logs();
        kick_and_wait();
        check("R9 empty underflow", ucnt, 1);
        check("R9 no transfer", nx, 0);
    endtask

    initial begin
        clear_logs();
        repeat (4) @(posedge clk);
        #1;
        t_reset();
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        t_reset();
        t_read_cmd();
        t_fast_read();
        t_quad_io();
        t_unknown();
        t_persist();
        t_single_lane();
        t_odd_tail();
        t_overflow();
        t_empty();
        finish_up();
    end

endmodule